// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Generator

This block turns single requests from an internal port into timed cycles on an external asynchronous memory bus. A request carries an address, write data, two byte enables and a read/write flag. It is held on the port while `req_valid` is high. The block then runs a fixed phase sequence and pulses `req_ready` once, near the end of the cycle. For a read, the captured data sits on `rsp_rdata` from that point on.

Three static inputs set up the external side:
- `cfg_wide` picks an 8-bit or a 16-bit data bus.
- `cfg_split` picks the strobe style on a 16-bit bus. One style is a read strobe, one write strobe and a byte-high-enable. The other is a read strobe with separate low-lane and high-lane write strobes.
- `cfg_mux` places the address on the shared data pins first, marked by an address-latch-enable pulse. On a 16-bit multiplexed bus that address is shifted down by one bit.

The strobe width is set by `cfg_strb_len`. The two dual-purpose strobe pins are `bus_wr_n` and `bus_hi_n`.

Top module: `mux_bus_cycler`

## Requirements
- R1: While reset is held and in idle, `bus_rd_n`, `bus_wr_n` and `bus_hi_n` are high. `bus_ale`, `bus_ad_oe` and `req_ready` are low.
- R2: A request accepted at a clock edge in idle produces the following phases:
  - one address clock;
  - one ALE-fall clock;
  - `cfg_strb_len`+1 strobe clocks;
  - one recovery clock with all strobes high.
  After that the block is idle again, so a cycle takes `cfg_strb_len`+4 clocks.
- R3: With `cfg_wide`=1 and `cfg_split`=1, `bus_wr_n` acts as the low-lane write strobe and `bus_hi_n` as the high-lane write strobe. During a write strobe phase, `bus_wr_n` is low when `req_be[0]` is set and `bus_hi_n` is low when `req_be[1]` is set. A read drives only `bus_rd_n` low. A `req_be` of 00 counts as both lanes.
- R4: With `cfg_wide`=1 and `cfg_split`=0, lanes are encoded by `bus_hi_n` (byte-high-enable) and bit 0 of `bus_addr`, held from the address clock through recovery:
  - `req_be` 01 gives `bus_hi_n`=1 and bit 0=0;
  - `req_be` 10 gives `bus_hi_n`=0 and bit 0=1;
  - `req_be` 11 or 00 gives `bus_hi_n`=0 and bit 0=0.
  The pair `bus_hi_n`=1 with bit 0=1 never occurs. `bus_wr_n` or `bus_rd_n` is the strobe.
- R5: With `cfg_wide`=0, the read/write/byte-high set is used whatever `cfg_split` says:
  - `bus_hi_n` stays high;
  - bit 0 of `bus_addr` is `req_addr[0]`;
  - `req_be` has no effect;
  - write data is `req_wdata[7:0]` on `bus_ad_o[7:0]`, with the upper bits zero.
- R6: With `cfg_mux`=1 and `cfg_wide`=0, `bus_ad_o[7:0]` carries `req_addr[7:0]` during the address and ALE-fall clocks. `bus_ale` is high for the address clock only, so it falls while the address is still driven.
- R7: With `cfg_mux`=1 and `cfg_wide`=1, `bus_ad_o[7:0]` carries `req_addr[8:1]` during the address and ALE-fall clocks. Bit 0 stays on `bus_addr`, and `bus_ad_o[15:8]` is zero.
- R8: `bus_ad_oe` is high in exactly these clocks:
  - the address and ALE-fall clocks of multiplexed cycles;
  - the strobe and recovery clocks of writes.
  It is therefore low whenever `bus_rd_n` is low. With `cfg_mux`=0, `bus_ale` stays low. A 16-bit write drives all of `req_wdata`.
- R9: Read data is sampled from `bus_ad_i` on the last strobe clock and appears on `rsp_rdata`. In 8-bit mode it is zero-extended from `bus_ad_i[7:0]`.
- R10: `bus_rd_n` is never low in the same clock as an active write strobe.
- R11: `req_ready` is high for exactly one clock, the recovery clock. Changes to the request inputs after acceptance have no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 = 16-bit external data bus, 0 = 8-bit |
| cfg_split | input | 1 | 1 = separate lane write strobes (16-bit only) |
| cfg_mux | input | 1 | 1 = address multiplexed onto data pins |
| cfg_strb_len | input | LEN_W | Strobe clocks minus one |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Lane-aligned write data |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data of the last read |
| bus_addr | output | ADDR_W | Separate address pins, bit 0 lane-encoded on a 16-bit bus |
| bus_ad_o | output | 16 | Shared address/data pins, output value |
| bus_ad_oe | output | 1 | Output enable for the shared pins |
| bus_ad_i | input | 16 | Shared address/data pins, input value |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe or low-lane write strobe, active low |
| bus_hi_n | output | 1 | Byte-high-enable or high-lane write strobe, active low |

## Verification
Read-data capture and strobe release share one clock edge: the last strobe clock ends, `bus_rd_n` rises, and `rsp_rdata` loads. The bench model returns a pattern while `bus_rd_n` is low and its complement as soon as it rises, so a capture one clock late reads back inverted. The completion pulse also shares its clock with the requester's next move. The bench holds `req_valid` high through recovery, scrambles `req_addr` right after acceptance, and drops `req_valid` only after seeing `req_ready`. The run is judged by the next cycle starting cleanly and by every pin matching values computed from the original request. This is done across every combination of width, strobe style, multiplexing, direction, byte enables and strobe length.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALEF,
        ST_STRB,
        ST_RCVR
    } cyc_e;

endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 2,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic [LEN_W-1:0]  cfg_strb_len,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [1:0]        req_be,
    input  logic [DW-1:0]     bus_ad_i,
    output cyc_e              st,
    output logic              cur_we,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DW-1:0]     cur_wdata,
    output logic [1:0]        cur_be,
    output logic [DW-1:0]     rdata,
    output logic              ready
);
    localparam int HB = DW / 2;

    typedef struct packed {
        cyc_e              st;
        logic [LEN_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [1:0]        be;
        logic [DW-1:0]     rdata;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_ADDR;
                    r_d.we    = req_we;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be    = req_be;
                end
            end
            ST_ADDR: r_d.st = ST_ALEF;
            ST_ALEF: begin
                r_d.st  = ST_STRB;
                r_d.cnt = cfg_strb_len;
            end
            ST_STRB: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_RCVR;
                    if (!r_q.we)
                        r_d.rdata = cfg_wide ? bus_ad_i : {{HB{1'b0}}, bus_ad_i[HB-1:0]};
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RCVR: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st        = r_q.st;
    assign cur_we    = r_q.we;
    assign cur_addr  = r_q.addr;
    assign cur_wdata = r_q.wdata;
    assign cur_be    = r_q.be;
    assign rdata     = r_q.rdata;
    assign ready     = (r_q.st == ST_RCVR);

    // R11: captured request held for the whole cycle
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(r_q.addr) && $stable(r_q.we) && $stable(r_q.be)));

    // R11: completion pulse is a single clock
    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R2: recovery always returns to idle
    p_rcvr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RCVR) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/mbc_strobe_dec.sv
module mbc_strobe_dec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wide,
    input  logic       cfg_split,
    input  logic       we,
    input  logic       addr0,
    input  logic [1:0] be,
    input  logic       strb,
    input  logic       busy,
    output logic       a0,
    output logic       rd_n,
    output logic       wr_n,
    output logic       hi_n
);
    logic [1:0] lanes;
    logic       split_eff;

    always_comb begin
        lanes     = (be == 2'b00) ? 2'b11 : be;
        split_eff = cfg_wide && cfg_split;
        a0        = cfg_wide ? (lanes == 2'b10) : addr0;
        rd_n      = !(strb && !we);
        if (split_eff) begin
            wr_n = !(strb && we && lanes[0]);
            hi_n = !(strb && we && lanes[1]);
        end else begin
            wr_n = !(strb && we);
            hi_n = cfg_wide ? !(busy && lanes[1]) : 1'b1;
        end
    end

    // R4: byte-high-enable high together with address bit 0 high is never driven
    p_no_void_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wide && !cfg_split) |-> !(hi_n && a0));

    // R5: byte-high-enable unused on an 8-bit bus
    p_narrow_hi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wide |-> hi_n);

endmodule

// File: rtl/mux_bus_cycler.sv
module mux_bus_cycler
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_split,
    input  logic              cfg_mux,
    input  logic [LEN_W-1:0]  cfg_strb_len,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [15:0]       bus_ad_i,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_hi_n
);
    localparam int DW = 16;
    localparam int HB = DW / 2;

    cyc_e              st;
    logic              cur_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [DW-1:0]     cur_wdata;
    logic [1:0]        cur_be;
    logic              a0;
    logic              strb, busy, aphase, dphase;

    mbc_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wide     (cfg_wide),
        .cfg_strb_len (cfg_strb_len),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .bus_ad_i     (bus_ad_i),
        .st           (st),
        .cur_we       (cur_we),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .cur_be       (cur_be),
        .rdata        (rsp_rdata),
        .ready        (req_ready)
    );

    assign strb   = (st == ST_STRB);
    assign busy   = (st != ST_IDLE);
    assign aphase = (st == ST_ADDR) || (st == ST_ALEF);
    assign dphase = (st == ST_STRB) || (st == ST_RCVR);

    mbc_strobe_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .cfg_split (cfg_split),
        .we        (cur_we),
        .addr0     (cur_addr[0]),
        .be        (cur_be),
        .strb      (strb),
        .busy      (busy),
        .a0        (a0),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .hi_n      (bus_hi_n)
    );

    always_comb begin
        bus_ad_o = '0;
        if (cfg_mux && aphase) begin
            bus_ad_o[HB-1:0] = cfg_wide ? cur_addr[HB:1] : cur_addr[HB-1:0];
        end else if (cur_we && dphase) begin
            bus_ad_o = cfg_wide ? cur_wdata : {{HB{1'b0}}, cur_wdata[HB-1:0]};
        end
    end

    assign bus_ad_oe = (cfg_mux && aphase) || (cur_we && dphase);
    assign bus_ale   = cfg_mux && (st == ST_ADDR);
    assign bus_addr  = busy ? {cur_addr[ADDR_W-1:1], a0} : '0;

    // R10: read strobe and any write strobe never low together
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_wr_n && !(cfg_wide && cfg_split && !bus_hi_n)));

    // R8: pads released while the read strobe is active
    p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    // R6: latch enable lasts one clock
    p_ale_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (!bus_ale && bus_ad_oe));

    // R2: strobes idle high whenever the sequencer is idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe));

endmodule

// File: tb/mux_bus_cycler_bench.sv
module mux_bus_cycler_bench;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wide, cfg_split, cfg_mux;
    logic [LEN_W-1:0]  cfg_strb_len;
    logic              req_valid, req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [15:0]       req_wdata;
    logic [1:0]        req_be;
    logic              req_ready;
    logic [15:0]       rsp_rdata;
    logic [ADDR_W-1:0] bus_addr;
    logic [15:0]       bus_ad_o;
    logic              bus_ad_oe;
    logic [15:0]       bus_ad_i;
    logic              bus_ale, bus_rd_n, bus_wr_n, bus_hi_n;
    logic [15:0]       pat;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    // external device: pattern while read strobe low, complement otherwise
    assign bus_ad_i = bus_rd_n ? ~pat : pat;

    mux_bus_cycler #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mux_bus_cycler (
        .clk(clk), .rst_n(rst_n),
        .cfg_wide(cfg_wide), .cfg_split(cfg_split), .cfg_mux(cfg_mux),
        .cfg_strb_len(cfg_strb_len),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_hi_n(bus_hi_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_checks(input string tag);
        chk(tag, "rd_n", bus_rd_n, 1);
        chk(tag, "wr_n", bus_wr_n, 1);
        chk(tag, "hi_n", bus_hi_n, 1);
        chk(tag, "ale", bus_ale, 0);
        chk(tag, "oe", bus_ad_oe, 0);
        chk(tag, "ready", req_ready, 0);
    endtask

    task automatic run_txn(input bit w, input bit s, input bit m, input bit we,
                           input logic [1:0] be, input int len, input logic [ADDR_W-1:0] a);
        int          nstr;
        logic [1:0]  lanes;
        logic        a0_e, busy, strb, rd_e, wr_e, hi_e, oe_e, ale_e;
        logic [15:0] ad_e, wd;
        string       stag;
        nstr  = len + 1;
        lanes = (be == 2'b00) ? 2'b11 : be;
        a0_e  = w ? (lanes == 2'b10) : a[0];
        wd    = 16'hC3A5 ^ {8'(len), 6'd0, be};
        stag  = !w ? "R5" : (s ? "R3" : "R4");
        pat   = 16'h9E61 ^ a[15:0];
        cfg_wide = w; cfg_split = s; cfg_mux = m; cfg_strb_len = LEN_W'(len);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
        for (int k = 0; k <= nstr + 3; k++) begin
            @(posedge clk);
            #(CLK_P/4);
            busy  = (k <= nstr + 2);
            strb  = (k >= 2) && (k < 2 + nstr);
            ale_e = m && (k == 0);
            rd_e  = !(strb && !we);
            if (w && s) begin
                wr_e = !(strb && we && lanes[0]);
                hi_e = !(strb && we && lanes[1]);
            end else begin
                wr_e = !(strb && we);
                hi_e = w ? !(busy && lanes[1]) : 1'b1;
            end
            oe_e = (m && k < 2) || (we && k >= 2 && busy);
            if (k < 2) ad_e = w ? {8'h00, a[8:1]} : {8'h00, a[7:0]};
            else       ad_e = w ? wd : {8'h00, wd[7:0]};
            chk(stag, "rd_n", bus_rd_n, rd_e);
            chk(stag, "wr_n", bus_wr_n, wr_e);
            chk(stag, "hi_n", bus_hi_n, hi_e);
            chk(m ? "R6" : "R8", "ale", bus_ale, ale_e);
            chk("R8", "oe", bus_ad_oe, oe_e);
            if (oe_e) chk(k < 2 ? (w ? "R7" : "R6") : "R8", "ad_o", bus_ad_o, ad_e);
            if (busy) chk(w ? "R4" : "R5", "addr", bus_addr, {a[ADDR_W-1:1], a0_e});
            chk("R11", "ready", req_ready, (k == nstr + 2));
            chk("R10", "strobe overlap",
                (!bus_rd_n && (!bus_wr_n || (w && s && !bus_hi_n))), 0);
            if (k == 0) begin
                // R11: scramble the request after acceptance
                req_addr = ~a; req_wdata = ~wd; req_be = ~be; req_we = ~we;
            end
            if (k == nstr + 2) req_valid = 1'b0;
        end
        chk("R2", "idle after cycle", {bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe}, 4'b1100);
        if (!we) chk("R9", "rdata", rsp_rdata, w ? pat : {8'h00, pat[7:0]});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        pat = 16'h0;
        rst_n = 1'b0;
        cfg_wide = 1'b1; cfg_split = 1'b0; cfg_mux = 1'b1; cfg_strb_len = '0;
        req_valid = 1'b1; req_we = 1'b1; req_addr = '0; req_wdata = '0; req_be = 2'b11;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        idle_checks("R1");
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_P/4);
        idle_checks("R1");
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 2; m++)
                    for (int we = 0; we < 2; we++)
                        for (int be = 0; be < 4; be++)
                            for (int len = 0; len < 4; len++)
                                for (int ai = 0; ai < 2; ai++)
                                    run_txn(w[0], s[0], m[0], we[0], be[1:0], len,
                                            ai ? 20'h5A4C3 : 20'hA5B3C);
        idle_checks("R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule